// File: doc/BRIEF.md
# Receive Descriptor Chain Controller

This block is the receive engine of a network controller. Software builds a linked list of receive descriptors in memory and hands the list to the block with a start command. For each arriving frame the block reads the current descriptor's control word and link word, then writes completion status (complete, OK, byte count) back into that descriptor and moves on to the linked one. Two control bits in a descriptor stop the walk: a suspend bit parks the engine so that a resume command can continue at the saved link, while an end-of-list bit drops it into a no-resources state that only a fresh start command can leave. Frame-received and receiver-not-ready flags are raised in a status/acknowledge byte that the host clears by writing ones, and an interrupt line reports any unmasked pending flag.

The receive unit has four states. Idle is left by Start. Ready takes three transitions: a plain completion keeps it in Ready, a completion with the suspend bit set goes to Suspended, and one with the end-of-list bit set goes to NoResources. Suspended is left by Resume or Start, and NoResources only by Start. A second machine, the descriptor walker, steps WalkIdle to ReadControl to ReadLink to WriteStatus and back to WalkIdle. Each step waits for the memory acknowledge, and the last one produces the completion event that drives the receive-unit transitions. Frames that arrive outside Ready, or while a descriptor is still being processed, are dropped and counted.

Top module: `rxd_chain_ctrl`

## Requirements
- R1: After reset the receive unit is Idle (state code 4'b0000), the status/acknowledge byte is 8'h00, the interrupt is low, the drop counter is 0 and no memory request is raised.
- R2: A command with op 2'b01 (start) loads the descriptor address from `cmd_addr` and enters Ready (4'b0100) from any state; ops 2'b00 and 2'b11 have no effect; a command is taken only while no descriptor is in progress and no frame is accepted in the same cycle.
- R3: An accepted frame causes exactly three memory accesses: a read of word D (control: bit 31 end-of-list, bit 30 suspend), a read of word D+1 (link), then one write of word D that keeps bits [31:16], sets bit 15 (complete) and bit 13 (OK), clears bits 14, 12 and 11 and puts the frame length in bits [10:0]; a pending request holds its address and direction until acknowledged.
- R4: A completion with neither control bit set leaves the unit Ready with the next descriptor at the link, and sets the frame-received flag.
- R5: A completion with only the suspend bit moves the unit to Suspended (4'b0001) and sets both the frame-received and receiver-not-ready flags.
- R6: A completion with the end-of-list bit moves the unit to NoResources (4'b0010) and sets both flags, whether or not the suspend bit is also set.
- R7: Resume (op 2'b10) in Suspended returns to Ready, and the next frame's first read is at the link saved from the suspending descriptor; resume in any other state is ignored.
- R8: NoResources is left only by start; resume and changes to descriptor memory do not wake it.
- R9: A frame strobe while the unit is not Ready, or while a descriptor is in progress, is dropped without memory access and increments a 16-bit counter that saturates at 16'hFFFF.
- R10: The device status byte is {cu_status[1:0], state code[3:0], 2'b00}; NoResources with cu_status 2'b01 reads 8'h48.
- R11: In the status/acknowledge byte bit 6 is frame-received and bit 4 is receiver-not-ready and all other bits read 0; an acknowledge write clears each bit written as 1, and a flag set in the same cycle as its clear stays set.
- R12: The interrupt output is high exactly when some status/acknowledge bit is set whose `irq_mask` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | Command: 00 none, 01 start, 10 resume, 11 reserved |
| cmd_addr | input | 32 | Descriptor list base word address for start |
| cu_status | input | 2 | Command-unit status reported in the status byte |
| dev_status | output | 8 | Device status byte |
| frm_valid | input | 1 | Frame arrival strobe |
| frm_len | input | 11 | Byte count of the arriving frame |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_data | input | 8 | Write-one-to-clear data for the status/acknowledge byte |
| irq_mask | input | 8 | Interrupt mask, 1 masks a flag |
| stat_ack | output | 8 | Pending interrupt flags |
| irq | output | 1 | Interrupt request |
| rsrc_err_cnt | output | 16 | Saturating count of dropped frames |
| mem_req | output | 1 | Descriptor memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |

## Verification
The completion of a descriptor and a host acknowledge write can land in the same cycle, one setting the frame-received and receiver-not-ready flags while the other clears them. The bench memory model provokes this by driving an acknowledge of 8'h50 in exactly the cycle in which it accepts the status write-back of a descriptor carrying the suspend bit. The case is judged correct only if both flags read as set afterwards and the unit is Suspended, while a separate acknowledge with no completion pending shows that the clear works on its own.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int DESC_W = 32;
    localparam int HALF_W = DESC_W / 2;
    localparam int EL_BIT = 31;
    localparam int SUS_BIT = 30;
    localparam int CMPL_BIT = 15;
    localparam int OK_BIT = 13;
    localparam int FLAG_W = 8;
    localparam int FR_BIT = 6;
    localparam int RNR_BIT = 4;

    typedef enum logic [3:0] {
        RU_IDLE  = 4'b0000,
        RU_SUSP  = 4'b0001,
        RU_NORES = 4'b0010,
        RU_READY = 4'b0100
    } ru_state_e;

    typedef enum logic [1:0] {
        CMD_NOP    = 2'b00,
        CMD_START  = 2'b01,
        CMD_RESUME = 2'b10,
        CMD_RSVD   = 2'b11
    } ru_cmd_e;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_RD_CTL,
        WK_RD_LINK,
        WK_WR_STS
    } walk_e;
endpackage

// File: rtl/rxd_sat_counter.sv
module rxd_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (inc && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign count = cnt_q;

    // R9: the count never wraps once full
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
    // R9: each drop below the limit adds exactly one
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/rxd_irq_regs.sv
module rxd_irq_regs
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_fr,
    input  logic              set_rnr,
    input  logic              ack_wr,
    input  logic [FLAG_W-1:0] ack_data,
    input  logic [FLAG_W-1:0] irq_mask,
    output logic [FLAG_W-1:0] stat_ack,
    output logic              irq
);
    logic [FLAG_W-1:0] set_vec;

    always_comb begin
        set_vec          = '0;
        set_vec[FR_BIT]  = set_fr;
        set_vec[RNR_BIT] = set_rnr;
    end

    // One sticky flag per bit; reserved bits have no set source.
    for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (set_vec[gi])
                flag_q <= 1'b1;
            else if (ack_wr && ack_data[gi])
                flag_q <= 1'b0;
        end
        assign stat_ack[gi] = flag_q;
    end

    assign irq = |(stat_ack & ~irq_mask);

    // R11: a set in the same cycle as a clear leaves the flag set
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_rnr |=> stat_ack[RNR_BIT]);
    // R11: an acknowledge without a new event clears the flag
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && ack_data[FR_BIT] && !set_fr) |=> !stat_ack[FR_BIT]);
endmodule

// File: rtl/rxd_walker.sv
module rxd_walker
    import rxd_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_walk,
    input  logic [DESC_W-1:0] walk_addr,
    input  logic [LEN_W-1:0]  walk_len,
    output logic              busy,
    output logic              done,
    output logic              done_el,
    output logic              done_sus,
    output logic [DESC_W-1:0] done_link,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DESC_W-1:0] mem_addr,
    output logic [DESC_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DESC_W-1:0] mem_rdata
);
    walk_e             ph_q, ph_d;
    logic [DESC_W-1:0] base_q, link_q;
    logic [HALF_W-1:0] ctl_hi_q;
    logic [LEN_W-1:0]  len_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= WK_IDLE;
        else
            ph_q <= ph_d;
    end

    // Captured descriptor fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            len_q    <= '0;
            ctl_hi_q <= '0;
            link_q   <= '0;
        end else begin
            if (ph_q == WK_IDLE && start_walk) begin
                base_q <= walk_addr;
                len_q  <= walk_len;
            end
            if (ph_q == WK_RD_CTL && mem_ack)
                ctl_hi_q <= mem_rdata[DESC_W-1:HALF_W];
            if (ph_q == WK_RD_LINK && mem_ack)
                link_q <= mem_rdata;
        end
    end

    // Next state
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            WK_IDLE:    if (start_walk) ph_d = WK_RD_CTL;
            WK_RD_CTL:  if (mem_ack) ph_d = WK_RD_LINK;
            WK_RD_LINK: if (mem_ack) ph_d = WK_WR_STS;
            WK_WR_STS:  if (mem_ack) ph_d = WK_IDLE;
            default:    ph_d = WK_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = base_q;
        mem_wdata = {ctl_hi_q, {HALF_W{1'b0}}};
        mem_wdata[CMPL_BIT]    = 1'b1;
        mem_wdata[OK_BIT]      = 1'b1;
        mem_wdata[LEN_W-1:0]   = len_q;
        unique case (ph_q)
            WK_IDLE:    mem_req = 1'b0;
            WK_RD_CTL:  mem_req = 1'b1;
            WK_RD_LINK: begin
                mem_req  = 1'b1;
                mem_addr = base_q + DESC_W'(1);
            end
            WK_WR_STS: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default:    mem_req = 1'b0;
        endcase
    end

    assign busy      = (ph_q != WK_IDLE);
    assign done      = (ph_q == WK_WR_STS) && mem_ack;
    assign done_el   = ctl_hi_q[EL_BIT-HALF_W];
    assign done_sus  = ctl_hi_q[SUS_BIT-HALF_W];
    assign done_link = link_q;

    // R3: a waiting request keeps its address and direction
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R3: the status write goes to the descriptor that was read first
    a_r3_write_home: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && ph_q == WK_RD_LINK) |=>
        (mem_we && mem_addr == $past(mem_addr) - DESC_W'(1)));
endmodule

// File: rtl/rxd_ru_fsm.sv
module rxd_ru_fsm
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DESC_W-1:0] cmd_addr,
    input  logic              frm_valid,
    input  logic              walk_busy,
    input  logic              done,
    input  logic              done_el,
    input  logic              done_sus,
    input  logic [DESC_W-1:0] done_link,
    output logic [3:0]        ru_code,
    output logic [DESC_W-1:0] next_desc,
    output logic              frm_accept,
    output logic              frm_drop,
    output logic              set_fr,
    output logic              set_rnr
);
    ru_state_e         ru_q, ru_d;
    logic [DESC_W-1:0] cur_q, cur_d;
    logic              cmd_take, is_start, is_resume;

    assign frm_accept = frm_valid && (ru_q == RU_READY) && !walk_busy;
    assign frm_drop   = frm_valid && !frm_accept;
    assign cmd_take   = cmd_valid && !walk_busy && !frm_accept;
    assign is_start   = cmd_take && (ru_cmd_e'(cmd_op) == CMD_START);
    assign is_resume  = cmd_take && (ru_cmd_e'(cmd_op) == CMD_RESUME);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ru_q  <= RU_IDLE;
            cur_q <= '0;
        end else begin
            ru_q  <= ru_d;
            cur_q <= cur_d;
        end
    end

    // Next state
    always_comb begin
        ru_d  = ru_q;
        cur_d = cur_q;
        unique case (ru_q)
            RU_IDLE, RU_NORES: begin
                if (is_start) begin
                    ru_d  = RU_READY;
                    cur_d = cmd_addr;
                end
            end
            RU_SUSP: begin
                if (is_start) begin
                    ru_d  = RU_READY;
                    cur_d = cmd_addr;
                end else if (is_resume) begin
                    ru_d = RU_READY;
                end
            end
            RU_READY: begin
                if (done) begin
                    if (done_el)
                        ru_d = RU_NORES;
                    else begin
                        cur_d = done_link;
                        if (done_sus)
                            ru_d = RU_SUSP;
                    end
                end else if (is_start) begin
                    cur_d = cmd_addr;
                end
            end
            default: ru_d = RU_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ru_code   = ru_q;
        next_desc = cur_q;
        set_fr    = done;
        set_rnr   = done && (done_el || done_sus);
    end

    // R6: end-of-list wins over suspend
    a_r6_el_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_el) |=> (ru_q == RU_NORES));
    // R7: resume keeps the saved link as the next descriptor
    a_r7_resume_link: assert property (@(posedge clk) disable iff (!rst_n)
        (is_resume && ru_q == RU_SUSP) |=> (ru_q == RU_READY && $stable(cur_q)));
    // R8: only start leaves NoResources
    a_r8_nores_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ru_q == RU_NORES && !is_start) |=> (ru_q == RU_NORES));
    // R9: no walk starts outside Ready
    a_r9_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (ru_q != RU_READY) |-> !frm_accept);
endmodule

// File: rtl/rxd_chain_ctrl.sv
module rxd_chain_ctrl
    import rxd_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DESC_W-1:0] cmd_addr,
    input  logic [1:0]        cu_status,
    output logic [7:0]        dev_status,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              ack_wr,
    input  logic [FLAG_W-1:0] ack_data,
    input  logic [FLAG_W-1:0] irq_mask,
    output logic [FLAG_W-1:0] stat_ack,
    output logic              irq,
    output logic [CNT_W-1:0]  rsrc_err_cnt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DESC_W-1:0] mem_addr,
    output logic [DESC_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DESC_W-1:0] mem_rdata
);
    logic              walk_busy, done, done_el, done_sus;
    logic [DESC_W-1:0] done_link, next_desc;
    logic              frm_accept, frm_drop, set_fr, set_rnr;
    logic [3:0]        ru_code;

    rxd_ru_fsm u_ru (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .frm_valid  (frm_valid),
        .walk_busy  (walk_busy),
        .done       (done),
        .done_el    (done_el),
        .done_sus   (done_sus),
        .done_link  (done_link),
        .ru_code    (ru_code),
        .next_desc  (next_desc),
        .frm_accept (frm_accept),
        .frm_drop   (frm_drop),
        .set_fr     (set_fr),
        .set_rnr    (set_rnr)
    );

    rxd_walker #(.LEN_W(LEN_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_walk (frm_accept),
        .walk_addr  (next_desc),
        .walk_len   (frm_len),
        .busy       (walk_busy),
        .done       (done),
        .done_el    (done_el),
        .done_sus   (done_sus),
        .done_link  (done_link),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    rxd_irq_regs u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_fr   (set_fr),
        .set_rnr  (set_rnr),
        .ack_wr   (ack_wr),
        .ack_data (ack_data),
        .irq_mask (irq_mask),
        .stat_ack (stat_ack),
        .irq      (irq)
    );

    rxd_sat_counter #(.CNT_W(CNT_W)) u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (frm_drop),
        .count (rsrc_err_cnt)
    );

    assign dev_status = {cu_status, ru_code, 2'b00};

    // R1: no memory traffic while the receive unit is Idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ru_code == 4'b0000) |-> !mem_req);
endmodule

// File: tb/sim_rxd_chain_ctrl.sv
module sim_rxd_chain_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NDESC = 8;
    localparam int WATCHDOG = 200000;
    localparam logic [3:0] S_IDLE = 4'b0000, S_SUSP = 4'b0001,
                           S_NORES = 4'b0010, S_READY = 4'b0100;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] cmd_addr = '0;
    logic [1:0]  cu_status = 2'b01;
    logic [7:0]  dev_status;
    logic        frm_valid = 1'b0;
    logic [10:0] frm_len = '0;
    logic        ack_wr;
    logic [7:0]  ack_data;
    logic        host_ack_wr = 1'b0;
    logic [7:0]  host_ack_data = '0;
    logic        coll_pulse;
    logic [7:0]  irq_mask = '0;
    logic [7:0]  stat_ack;
    logic        irq;
    logic [15:0] rsrc_err_cnt;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ack_wr   = host_ack_wr | coll_pulse;
    assign ack_data = coll_pulse ? 8'h50 : host_ack_data;

    rxd_chain_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cu_status(cu_status), .dev_status(dev_status),
        .frm_valid(frm_valid), .frm_len(frm_len), .ack_wr(ack_wr),
        .ack_data(ack_data), .irq_mask(irq_mask), .stat_ack(stat_ack),
        .irq(irq), .rsrc_err_cnt(rsrc_err_cnt), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [31:0] mem [0:63];
    int          wr_count = 0, acc_n = 0, lat = 0;
    logic [31:0] acc_addr [0:3];
    logic        acc_we [0:3];
    bit          coll_arm = 1'b0;

    int          checks = 0, fails = 0;
    bit          finished = 1'b0;
    logic [3:0]  m_ru = S_IDLE;
    logic [31:0] m_cur = '0;
    bit          m_fr = 1'b0, m_rnr = 1'b0;
    int          m_cnt = 0;

    // Descriptor memory model with random latency
    initial begin
        mem_ack = 1'b0; mem_rdata = '0; coll_pulse = 1'b0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0; coll_pulse = 1'b0;
            if (mem_req && rst_n) begin
                if (lat == 0) begin
                    mem_ack = 1'b1;
                    if (acc_n < 4) begin
                        acc_addr[acc_n] = mem_addr;
                        acc_we[acc_n]   = mem_we;
                    end
                    acc_n++;
                    if (mem_we) begin
                        mem[mem_addr[5:0]] = mem_wdata;
                        wr_count++;
                        if (coll_arm) begin
                            coll_pulse = 1'b1;
                            coll_arm   = 1'b0;
                        end
                    end else begin
                        mem_rdata = mem[mem_addr[5:0]];
                    end
                    lat = $urandom_range(2, 0);
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_flags();
        return {1'b0, m_fr, 1'b0, m_rnr, 4'b0000};
    endfunction

    function automatic logic [31:0] exp_wb(input logic [31:0] ctl, input logic [10:0] len);
        return {ctl[31:16], 16'hA000 | {5'b0, len}};
    endfunction

    task automatic check_all(input string ctx);
        check(dev_status == {cu_status, m_ru, 2'b00}, "R10", {ctx, " status"},
              dev_status, {cu_status, m_ru, 2'b00});
        check(stat_ack == exp_flags(), "R11", {ctx, " flags"}, stat_ack, exp_flags());
        check(irq == |(exp_flags() & ~irq_mask), "R12", {ctx, " irq"},
              irq, |(exp_flags() & ~irq_mask));
        check(rsrc_err_cnt == m_cnt[15:0], "R9", {ctx, " drops"}, rsrc_err_cnt, m_cnt);
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [31:0] addr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        if (op == 2'b01) begin
            m_ru = S_READY; m_cur = addr;
        end else if (op == 2'b10 && m_ru == S_SUSP) begin
            m_ru = S_READY;
        end
        check(dev_status[5:2] == m_ru, (op == 2'b10) ? "R7" : "R2", "command state",
              dev_status[5:2], m_ru);
        check_all("cmd");
    endtask

    task automatic do_ack(input logic [7:0] d);
        @(negedge clk);
        host_ack_wr = 1'b1; host_ack_data = d;
        @(negedge clk);
        host_ack_wr = 1'b0;
        #1;
        if (d[6]) m_fr = 1'b0;
        if (d[4]) m_rnr = 1'b0;
        check(stat_ack == exp_flags(), "R11", "ack clear", stat_ack, exp_flags());
        check_all("ack");
    endtask

    task automatic send_frame(input logic [10:0] len, input string rtag);
        bit          take;
        logic [31:0] ctl, lnk, expw;
        int          w0;
        take = (m_ru == S_READY);
        ctl  = mem[m_cur[5:0]];
        lnk  = mem[(m_cur[5:0] + 6'd1)];
        expw = exp_wb(ctl, len);
        acc_n = 0;
        w0 = wr_count;
        @(negedge clk);
        frm_valid = 1'b1; frm_len = len;
        @(negedge clk);
        frm_valid = 1'b0;
        #1;
        if (take) begin
            while (wr_count == w0) begin
                @(negedge clk);
                #1;
            end
            @(negedge clk);
            #1;
            check(acc_n == 3, "R3", "access count", acc_n, 3);
            check(acc_addr[0] == m_cur, rtag, "first read address", acc_addr[0], m_cur);
            check(acc_addr[1] == m_cur + 1 && !acc_we[1], "R3", "link read",
                  acc_addr[1], m_cur + 1);
            check(acc_we[2] && acc_addr[2] == m_cur, "R3", "status write address",
                  acc_addr[2], m_cur);
            check(mem[m_cur[5:0]] == expw, "R3", "status word", mem[m_cur[5:0]], expw);
            m_fr = 1'b1;
            if (ctl[31]) begin
                m_ru = S_NORES; m_rnr = 1'b1;
            end else begin
                m_cur = lnk;
                if (ctl[30]) begin
                    m_ru = S_SUSP; m_rnr = 1'b1;
                end
            end
            check(dev_status[5:2] == m_ru, ctl[31] ? "R6" : (ctl[30] ? "R5" : "R4"),
                  "state after completion", dev_status[5:2], m_ru);
        end else begin
            if (m_cnt < 65535) m_cnt++;
            check(acc_n == 0, "R9", "dropped frame touched memory", acc_n, 0);
        end
        check_all("frame");
    endtask

    task automatic build_ring(input bit rnd);
        for (int i = 0; i < NDESC; i++) begin
            logic el, sb;
            el = rnd && ($urandom_range(7, 0) == 0);
            sb = rnd && ($urandom_range(4, 0) == 0);
            mem[2*i]   = {el, sb, 30'h0};
            mem[2*i+1] = 32'(2 * ((i + 1) % NDESC));
        end
    endtask

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd41527));
        for (int i = 0; i < 64; i++) mem[i] = '0;
        build_ring(1'b0);
        mem[4]  = 32'h4000_0000;           // descriptor 2: suspend
        mem[10] = 32'hC000_0000;           // descriptor 5: end-of-list and suspend
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(dev_status == {cu_status, 4'b0000, 2'b00}, "R1", "reset status", dev_status, 8'h40);
        check(stat_ack == 8'h00, "R1", "reset flags", stat_ack, 0);
        check(!irq && !mem_req, "R1", "reset irq/req", {irq, mem_req}, 0);
        check(rsrc_err_cnt == 16'h0, "R1", "reset counter", rsrc_err_cnt, 0);

        do_cmd(2'b10, 32'h0);               // R7 resume in Idle ignored
        do_cmd(2'b11, 32'h8);               // R2 reserved op ignored
        do_cmd(2'b01, 32'h0);               // R2 start
        send_frame(11'd64, "R4");
        send_frame(11'd1518, "R4");
        send_frame(11'd2047, "R5");         // suspend descriptor
        send_frame(11'd60, "R9");           // dropped in Suspended
        do_cmd(2'b10, 32'h0);               // R7 resume
        send_frame(11'd100, "R7");          // must read at saved link 6
        send_frame(11'd200, "R4");
        send_frame(11'd300, "R6");          // both bits: NoResources
        check(dev_status == 8'h48, "R10", "NoResources byte", dev_status, 8'h48);
        do_cmd(2'b10, 32'h0);               // R8 resume ignored
        mem[10] = 32'h0;                    // R8 clearing bits does not wake
        send_frame(11'd40, "R8");
        check(dev_status[5:2] == S_NORES, "R8", "still NoResources", dev_status[5:2], S_NORES);
        do_cmd(2'b01, 32'd10);              // R8 start leaves NoResources
        do_ack(8'h50);
        send_frame(11'd77, "R4");
        irq_mask = 8'h40; #1;
        check(irq == 1'b0, "R12", "masked irq", irq, 0);
        irq_mask = 8'h00; #1;
        check(irq == 1'b1, "R12", "unmasked irq", irq, 1);
        // Collision: completion with suspend and acknowledge in the same cycle
        mem[12] = 32'h4000_0000;
        coll_arm = 1'b1;
        send_frame(11'd5, "R5");
        check(stat_ack == 8'h50, "R11", "set wins over clear", stat_ack, 8'h50);
        do_ack(8'h40);
        check(stat_ack == 8'h10, "R11", "partial clear", stat_ack, 8'h10);

        // Constrained random phase
        for (int it = 0; it < 400; it++) begin
            int r;
            r = $urandom_range(9, 0);
            if (r == 0) begin
                build_ring(1'b1);
                do_cmd(2'b01, 32'(2 * $urandom_range(NDESC - 1, 0)));
            end else if (r == 1) begin
                do_cmd(2'b10, 32'h0);
            end else if (r == 2) begin
                do_ack(8'($urandom));
            end else if (r == 3) begin
                @(negedge clk);
                irq_mask = 8'($urandom) & 8'h50;
                cu_status = 2'($urandom);
                #1;
                check_all("mask");
            end else begin
                send_frame(11'($urandom), "R3");
            end
        end

        // Saturation of the drop counter
        build_ring(1'b0);
        mem[0] = 32'h8000_0000;
        do_cmd(2'b01, 32'h0);
        send_frame(11'd9, "R6");
        @(negedge clk);
        frm_valid = 1'b1;
        repeat (65600) @(negedge clk);
        frm_valid = 1'b0;
        #1;
        m_cnt = 65535;
        check(rsrc_err_cnt == 16'hFFFF, "R9", "saturated counter", rsrc_err_cnt, 16'hFFFF);
        check_all("end");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule